// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block holds the control and status registers for a set of general-purpose I/O pins. The pins are grouped into ports of eight and banks of four ports, and there are a configurable number of banks. Each port has three writable registers and one read-only register. The first writable register selects, per pin, whether the register file or an alternate-function source owns the pad. The second sets the output enable, and the third holds the output value. The read-only register reports the pin levels after they pass through a two-stage synchronizer.

Software reaches the registers over a simple synchronous bus. A write completes in the cycle `wr_en` is high, and read data is registered one cycle after the address is presented. Every writable register can also be reached through a second address window. In that window the upper byte of the write data selects which bits of the lower byte are applied. This lets one driver flip a single pin without a read-modify-write, so it cannot race with another agent that is updating a neighbouring pin in the same port. To turn a pin into an output cleanly, software loads the output value first and sets the output enable afterwards.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every pin's ownership bit, output enable and output value read as zero, so every pad follows `alt_out` and `alt_oe`.
- R2: The byte address of a register is alias*0x800 + bank*0x80 + reg*0x10 + port*4. The reg code is 0 for ownership, 1 for output enable, 2 for output value and 3 for pin input. Address bits [1:0] are ignored, and reads through the alias window (alias=1) return the same register as the plain window (alias=0).
- R3: A write at a plain address (bit 11 clear) loads all eight bits of the register from `wdata[7:0]`, and `wdata[31:8]` has no effect.
- R4: A write at an alias address (bit 11 set) updates register bit n from `wdata[n]` only when `wdata[n+8]` is 1. All other bits hold their value, and `wdata[31:16]` has no effect.
- R5: Read data for the address presented at a rising edge appears on `rdata` after that edge, in bits [7:0], with bits [31:8] zero.
- R6: The pin-input register returns `pad_in` delayed by a two-flop synchronizer. A level applied just before edge k is visible to a read whose address is presented at edge k+2, and writes to the input register through either window have no effect.
- R7: For a pin whose ownership bit is 1, `pad_out` equals its output-value bit and `pad_oe` equals its output-enable bit.
- R8: For a pin whose ownership bit is 0, `pad_out` and `pad_oe` follow that pin's `alt_out` and `alt_oe` bits, whatever the register file holds for it.
- R9: An address whose bank field (bits [10:7]) is not below the bank count, or whose bit 6 is set, is not decoded. Writes to such an address change no register, and reads from it return zero.
- R10: A write changes only the addressed register of the addressed port. Every other register in every port keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte address of the register |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 32 | Write data; [15:8] is the bit mask in the alias window |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | NUM_BANKS*32 | Asynchronous pin levels |
| alt_out | input | NUM_BANKS*32 | Alternate-function output value per pin |
| alt_oe | input | NUM_BANKS*32 | Alternate-function output enable per pin |
| pad_out | output | NUM_BANKS*32 | Output value driven to each pad |
| pad_oe | output | NUM_BANKS*32 | Output enable driven to each pad |

## Verification
The hardest state to reach from the ports is a port where the ownership bits are mixed, so that some pins of one byte follow the register file and others follow the alternate source. The stimulus builds this state with a full masked write that hands the whole port to the register file. It then follows with a single-bit masked write that clears one ownership bit, and toggles `alt_out` while the state is held. The synchronizer latency is pinned down by issuing three back-to-back reads of the input register, starting in the same cycle the pin pattern changes. The first two must return the stale value and the third must return the new one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W         = 8;
    localparam int PORTS_PER_BANK = 4;
    localparam int ADDR_W         = 12;
    localparam int DATA_W         = 32;

    // Address field positions (byte address)
    localparam int PORT_LSB     = 2;
    localparam int PORT_FIELD_W = $clog2(PORTS_PER_BANK);
    localparam int REG_LSB      = 4;
    localparam int REG_FIELD_W  = 2;
    localparam int HOLE_BIT     = REG_LSB + REG_FIELD_W;
    localparam int BANK_LSB     = 7;
    localparam int BANK_FIELD_W = 4;
    localparam int ALIAS_BIT    = 11;
    localparam int FLAT_W       = BANK_FIELD_W + PORT_FIELD_W;

    typedef enum logic [REG_FIELD_W-1:0] {
        REG_OWN = 2'd0,
        REG_OE  = 2'd1,
        REG_OUT = 2'd2,
        REG_IN  = 2'd3
    } gpio_reg_e;

    typedef struct packed {
        logic              hit;
        logic              masked;
        gpio_reg_e         sel;
        logic [FLAT_W-1:0] flat;
    } gpio_dec_t;

    typedef struct packed {
        logic [PORT_W-1:0] own;
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] out;
        logic [PORT_W-1:0] inp;
    } port_view_t;

    // New register value: all bits, or only the bits enabled by the mask byte
    function automatic logic [PORT_W-1:0] merge_write(
        input logic [PORT_W-1:0]   cur,
        input logic [2*PORT_W-1:0] wd,
        input logic                masked
    );
        logic [PORT_W-1:0] en;
        en = masked ? wd[2*PORT_W-1:PORT_W] : {PORT_W{1'b1}};
        return (cur & ~en) | (wd[PORT_W-1:0] & en);
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_dec_t         dec
);

    logic [BANK_FIELD_W-1:0] bank;
    logic                    bank_ok;
    logic [1:0]              unused_byte_lane;

    assign bank             = addr[BANK_LSB +: BANK_FIELD_W];
    assign bank_ok          = ({1'b0, bank} < (BANK_FIELD_W+1)'(NUM_BANKS));
    assign unused_byte_lane = addr[1:0];

    always_comb begin
        dec.hit    = bank_ok && !addr[HOLE_BIT];
        dec.masked = addr[ALIAS_BIT];
        dec.sel    = gpio_reg_e'(addr[REG_LSB +: REG_FIELD_W]);
        dec.flat   = {bank, addr[PORT_LSB +: PORT_FIELD_W]};
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  gpio_reg_e           sel,
    input  logic                masked,
    input  logic [2*PORT_W-1:0] wd,
    input  logic [PORT_W-1:0]   pad_in,
    input  logic [PORT_W-1:0]   alt_out,
    input  logic [PORT_W-1:0]   alt_oe,
    output logic [PORT_W-1:0]   pad_out,
    output logic [PORT_W-1:0]   pad_oe,
    output port_view_t          view
);

    logic [PORT_W-1:0] own_q, oe_q, out_q;
    logic [PORT_W-1:0] meta_q, sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= '0;
            oe_q   <= '0;
            out_q  <= '0;
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            if (wr_stb) begin
                unique case (sel)
                    REG_OWN: own_q <= merge_write(own_q, wd, masked);
                    REG_OE:  oe_q  <= merge_write(oe_q,  wd, masked);
                    REG_OUT: out_q <= merge_write(out_q, wd, masked);
                    default: ;
                endcase
            end
        end
    end

    // Per-pin ownership mux between the register file and the alternate source
    always_comb begin
        pad_out = (own_q & out_q) | (~own_q & alt_out);
        pad_oe  = (own_q & oe_q)  | (~own_q & alt_oe);
    end

    assign view = '{own: own_q, oe: oe_q, out: out_q, inp: sync_q};

    // Counts clean cycles since reset so the latency check never looks into reset
    logic [1:0] settle_q;
    always_ff @(posedge clk) begin
        if (rst)                settle_q <= '0;
        else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
    end

    p_sync_two_stage_r6: assert property (@(posedge clk) disable iff (rst)
        (settle_q == 2'd2) |-> (view.inp == $past(pad_in, 2)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> ($stable(own_q) && $stable(oe_q) && $stable(out_q)));

    p_plain_load_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !masked && sel == REG_OUT) |=> (out_q == $past(wd[PORT_W-1:0])));

    p_mask_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && masked && sel == REG_OUT)
        |=> (((out_q ^ $past(out_q)) & ~$past(wd[2*PORT_W-1:PORT_W])) == '0));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic                                   wr_en,
    input  logic [DATA_W-1:0]                      wdata,
    output logic [DATA_W-1:0]                      rdata,
    input  logic [NUM_BANKS*PORTS_PER_BANK*PORT_W-1:0] pad_in,
    input  logic [NUM_BANKS*PORTS_PER_BANK*PORT_W-1:0] alt_out,
    input  logic [NUM_BANKS*PORTS_PER_BANK*PORT_W-1:0] alt_oe,
    output logic [NUM_BANKS*PORTS_PER_BANK*PORT_W-1:0] pad_out,
    output logic [NUM_BANKS*PORTS_PER_BANK*PORT_W-1:0] pad_oe
);

    localparam int NUM_PORTS = NUM_BANKS * PORTS_PER_BANK;

    gpio_dec_t         dec;
    port_view_t        views [NUM_PORTS];
    logic [PORT_W-1:0] rd_byte;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-2*PORT_W-1:0] unused_wdata_hi;

    assign unused_wdata_hi = wdata[DATA_W-1:2*PORT_W];

    gpio_addr_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit_p;
        assign hit_p = wr_en && dec.hit && (dec.flat == FLAT_W'(p));

        gpio_port u_port (
            .clk     (clk),
            .rst     (rst),
            .wr_stb  (hit_p),
            .sel     (dec.sel),
            .masked  (dec.masked),
            .wd      (wdata[2*PORT_W-1:0]),
            .pad_in  (pad_in [p*PORT_W +: PORT_W]),
            .alt_out (alt_out[p*PORT_W +: PORT_W]),
            .alt_oe  (alt_oe [p*PORT_W +: PORT_W]),
            .pad_out (pad_out[p*PORT_W +: PORT_W]),
            .pad_oe  (pad_oe [p*PORT_W +: PORT_W]),
            .view    (views[p])
        );
    end

    always_comb begin
        rd_byte = '0;
        if (dec.hit) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (dec.flat == FLAT_W'(p)) begin
                    unique case (dec.sel)
                        REG_OWN: rd_byte = views[p].own;
                        REG_OE:  rd_byte = views[p].oe;
                        REG_OUT: rd_byte = views[p].out;
                        default: rd_byte = views[p].inp;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= {{(DATA_W-PORT_W){1'b0}}, rd_byte};
    end

    assign rdata = rdata_q;

    p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !dec.hit |=> (rdata == '0));

endmodule

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb;
    import gpio_pkg::*;

    localparam int NB = 2;
    localparam int NP = NB * PORTS_PER_BANK * PORT_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [DATA_W-1:0] wdata, rdata;
    logic [NP-1:0]     pad_in, alt_out, alt_oe, pad_out, pad_oe;

    gpio_bank_regs #(.NUM_BANKS(NB)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];
    bit rd_issue = 0;
    bit rd_pend  = 0;

    function automatic logic [ADDR_W-1:0] ra(bit al, int b, int r, int p);
        return ADDR_W'((al ? 'h800 : 0) + b * 'h80 + r * 'h10 + p * 4);
    endfunction

    task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: every task starts at a falling edge and returns at the next one
    task automatic rd(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] e, string tag);
        addr = a; wr_en = 1'b0; rd_issue = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        addr = a; wdata = d; wr_en = 1'b1; rd_issue = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        rd_issue = 1'b0; wr_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: one read result per cycle after each issued read
    always @(posedge clk) rd_pend <= rd_issue;

    always @(negedge clk) begin : mon
        logic [DATA_W-1:0] e;
        string t;
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R5 unexpected read result: actual %h expected none", rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, NP'(rdata), NP'(e));
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    logic [NP-1:0] exp_out, exp_oe;

    initial begin
        addr = '0; wr_en = 1'b0; wdata = '0; pad_in = '0;
        alt_out = 64'hDEAD_BEEF_0123_4567;
        alt_oe  = 64'h5555_5555_5555_5555;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(ra(0,0,0,0), 32'h0, "R1 own reg after reset");
        rd(ra(0,0,1,0), 32'h0, "R1 oe reg after reset");
        rd(ra(0,1,2,3), 32'h0, "R1 out reg after reset");
        idle(1);
        check("R1 pad_out follows alt", pad_out, alt_out);
        check("R1 pad_oe follows alt", pad_oe, alt_oe);

        // R3 plain write ignores upper data
        wr(ra(0,0,2,1), 32'h1234_FF5A);
        rd(ra(0,0,2,1), 32'h5A, "R3 plain write");

        // R4 masked writes
        wr(ra(1,0,2,1), 32'h0000_0F03);
        rd(ra(0,0,2,1), 32'h53, "R4 low nibble masked");
        wr(ra(1,0,2,1), 32'h0000_00FF);
        rd(ra(0,0,2,1), 32'h53, "R4 empty mask");
        wr(ra(1,0,2,1), 32'hFFFF_FFC3);
        rd(ra(0,0,2,1), 32'hC3, "R4 full mask");

        // R2 alias window read
        rd(ra(1,0,2,1), 32'hC3, "R2 alias read");

        // R7 register-owned port: value first, then enable, then ownership
        wr(ra(0,1,2,2), 32'h3C);
        wr(ra(0,1,1,2), 32'hF0);
        wr(ra(1,1,0,2), 32'h0000_FFFF);
        idle(1);
        exp_out = alt_out; exp_out[55:48] = 8'h3C;
        exp_oe  = alt_oe;  exp_oe[55:48]  = 8'hF0;
        check("R7 pad_out owned port", pad_out, exp_out);
        check("R7 pad_oe owned port", pad_oe, exp_oe);

        // R8 hand one pin back to the alternate source
        wr(ra(1,1,0,2), 32'h0000_0100);
        idle(1);
        exp_out[48] = alt_out[48];
        exp_oe[48]  = alt_oe[48];
        check("R8 pad_out mixed port", pad_out, exp_out);
        check("R8 pad_oe mixed port", pad_oe, exp_oe);
        alt_out = ~alt_out;
        #1;
        check("R8 alt pins track alt_out", NP'(pad_out[47:0]), NP'(alt_out[47:0]));
        check("R7 owned pins hold", NP'(pad_out[55:49]), NP'(7'h1E));
        check("R8 owned-off pin tracks", NP'(pad_out[48]), NP'(alt_out[48]));

        // R6 synchronizer latency
        pad_in = 64'h9A00_0000_0000_00C7;
        rd(ra(0,0,3,0), 32'h0,  "R6 first read stale");
        rd(ra(0,0,3,0), 32'h0,  "R6 second read stale");
        rd(ra(0,0,3,0), 32'hC7, "R6 third read settled");
        rd(ra(0,1,3,3), 32'h9A, "R6 last port input");
        wr(ra(0,0,3,0), 32'hFFFF_FFFF);
        wr(ra(1,0,3,0), 32'h0000_FF00);
        rd(ra(0,0,3,0), 32'hC7, "R6 input writes ignored");

        // R9 undecoded addresses
        wr(ra(0,2,2,0), 32'hFF);
        rd(ra(0,2,2,0), 32'h0, "R9 missing bank reads zero");
        rd(ra(0,0,2,0), 32'h0, "R9 bank0 untouched");
        wr(12'h040, 32'hFF);
        rd(12'h040, 32'h0, "R9 hole reads zero");
        rd(ra(0,0,0,0), 32'h0, "R9 own reg untouched");

        // R10 isolation
        wr(ra(0,0,2,2), 32'h77);
        rd(ra(0,0,2,2), 32'h77, "R10 target port");
        rd(ra(0,0,2,1), 32'hC3, "R10 neighbour port");
        rd(ra(0,0,2,3), 32'h0,  "R10 other port");
        rd(ra(0,0,1,2), 32'h0,  "R10 other register");

        // R5 zero-extended read of the owned port
        rd(ra(0,1,2,2), 32'h0000_003C, "R5 upper bits zero");

        idle(3);
        check("R5 all reads returned", NP'(exp_q.size()), NP'(0));
        finished = 1;
        summary();
        $finish;
    end

endmodule